// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a bank of general-purpose output pins, each of which can serve as a serial-peripheral chip select. A configuration register marks, pin by pin, whether the pin is a select line and whether its driven level is inverted. A write-only force register changes the stored output values through two separate halves, one that sets and one that clears, so that any subset of pins can be moved in a single write without first reading the register back.

A second path lets a transfer sequencer assert or release a select by its logical number. The number is offset by a programmable base, so logical select `id` controls pin `id - base`. This path acts only on pins that are in select mode and lies inside the configured select count. A registered read port returns the configuration and the stored output values. The driven pin level is the stored value XOR the pin's inversion bit, so a device with an active-high select is served by setting its inversion bit and keeping the same set and clear writes.

Top module: `csel_out_ctrl`

## Requirements
- R1: After reset every stored output value is 1, the configuration register is 0, every pin drives 1 and every pin is flagged as a general-purpose output.
- R2: A write to register address 0 loads the configuration. Bits 15:8 put pins 7..0 into select mode and bits 7:0 invert pins 7..0. A read of address 0 returns the value written.
- R3: A write to address 1 (the force register) with bit 8+n at 1 sets stored output n, and with bit n at 1 clears it. Bits written as 0 leave their outputs unchanged. Writing 0xFF00 sets all eight outputs.
- R4: When the set bit and the clear bit of one pin are both 1 in one force write, the pin is cleared.
- R5: Each pin drives its stored value XOR its inversion bit.
- R6: A read of address 2 returns the eight stored output values in bits 7:0 and zero above. A read of the force register (address 1) returns 0.
- R7: The general-purpose flag of pin n is 1 exactly when configuration bit 8+n is 0.
- R8: A logical select strobe with number `id` targets pin `id - CS_BASE` (default base 1). `sel_on=1` clears that pin's stored value and `sel_on=0` sets it. The strobe has effect only when the pin is in select mode.
- R9: A logical select whose number is below CS_BASE, or at or beyond CS_BASE plus the select count (default 8), changes no stored value.
- R10: A force write and a logical select in the same cycle both take effect. Where they touch the same pin with opposite actions, the clear wins.
- R11: Read data appears with `bus_rvalid` high in the cycle after the read strobe. `bus_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 config, 1 force, 2 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| sel_stb | input | 1 | Logical select request strobe |
| sel_id | input | 4 | Logical select number |
| sel_on | input | 1 | 1 asserts (clears stored value), 0 releases (sets) |
| pin_out | output | 8 | Driven pin levels |
| pin_gpo | output | 8 | Per-pin general-purpose output flag |

## Verification
The bench uses the default parameters: eight pins, a select base of 1, a select count of 8 and a 4-bit select number. With a 4-bit number, the values 0 (below the base) and 9 through 15 (past the count) can be driven, so both sides of the out-of-range rule are exercised along with the edge numbers 1 and 8. With eight select-mode bits split between select and general-purpose pins, a strobe aimed at a pin not in select mode can also be shown to have no effect.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CFG    = 2'd0,
        REG_FORCE  = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic logic id_in_range(input int unsigned id,
                                         input int unsigned base,
                                         input int unsigned count);
        return (id >= base) && (id < base + count);
    endfunction

endpackage

// File: rtl/csel_cfg_reg.sv
module csel_cfg_reg
    import csel_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_cmd_t              cmd,
    input  logic [2*NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0]   cs_mode,
    output logic [NUM_PINS-1:0]   invert
);
    localparam int unsigned CFG_W = 2 * NUM_PINS;

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_we;

    assign cfg_we = cmd.wr && (cmd.sel == REG_CFG);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= wdata;
    end

    assign cs_mode = cfg_q[CFG_W-1:NUM_PINS];
    assign invert  = cfg_q[NUM_PINS-1:0];

    // R2: a config write is visible on the next cycle
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> ({cs_mode, invert} == $past(wdata)));

endmodule

// File: rtl/csel_lsel.sv
module csel_lsel
    import csel_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned CS_BASE  = 1,
    parameter int unsigned NUM_CS   = 8,
    parameter int unsigned ID_W     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_stb,
    input  logic [ID_W-1:0]     sel_id,
    input  logic                sel_on,
    input  logic [NUM_PINS-1:0] cs_mode,
    output logic [NUM_PINS-1:0] set_m,
    output logic [NUM_PINS-1:0] clr_m
);
    localparam int unsigned EFF_CS = (NUM_CS < NUM_PINS) ? NUM_CS : NUM_PINS;

    logic [NUM_PINS-1:0] hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i < EFF_CS) begin : g_sel
            assign hit[i] = sel_stb && cs_mode[i] &&
                            (32'(sel_id) == 32'(CS_BASE + i));
        end else begin : g_gpo
            assign hit[i] = 1'b0;
        end
    end

    assign clr_m = sel_on  ? hit : '0;
    assign set_m = !sel_on ? hit : '0;

    // R9: numbers outside the select window touch nothing
    a_r9_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (sel_stb && !id_in_range(32'(sel_id), CS_BASE, EFF_CS))
        |-> (set_m == '0 && clr_m == '0));

    // R8: a strobe reaches at most one pin
    a_r8_one_pin: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_m | clr_m));

endmodule

// File: rtl/csel_state.sv
module csel_state #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] set_m,
    input  logic [NUM_PINS-1:0] clr_m,
    output logic [NUM_PINS-1:0] stored
);
    logic [NUM_PINS-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '1;
        else     out_q <= (out_q | set_m) & ~clr_m;
    end

    assign stored = out_q;

    // R3: a set-only bit reads 1 afterwards
    a_r3_set: assert property (@(posedge clk) disable iff (rst)
        (|(set_m & ~clr_m)) |=>
        ((stored & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));

    // R3: no request, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (set_m == '0 && clr_m == '0) |=> $stable(stored));

    // R4: a clear always lands, even against a set
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (|clr_m) |=> ((stored & $past(clr_m)) == '0));

endmodule

// File: rtl/csel_out_ctrl.sv
module csel_out_ctrl
    import csel_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned CS_BASE  = 1,
    parameter int unsigned NUM_CS   = 8,
    parameter int unsigned ID_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [2*NUM_PINS-1:0] bus_wdata,
    output logic [2*NUM_PINS-1:0] bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  sel_stb,
    input  logic [ID_W-1:0]       sel_id,
    input  logic                  sel_on,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_gpo
);
    localparam int unsigned DATA_W = 2 * NUM_PINS;

    bus_cmd_t            cmd;
    logic [NUM_PINS-1:0] cs_mode, invert, stored;
    logic [NUM_PINS-1:0] frc_set, frc_clr, ls_set, ls_clr;
    logic [DATA_W-1:0]   rd_next, rdata_q;
    logic                rvalid_q;

    assign cmd.wr  = bus_wr;
    assign cmd.rd  = bus_rd;
    assign cmd.sel = reg_sel_e'(bus_addr);

    csel_cfg_reg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata),
        .cs_mode(cs_mode), .invert(invert)
    );

    csel_lsel #(.NUM_PINS(NUM_PINS), .CS_BASE(CS_BASE),
                .NUM_CS(NUM_CS), .ID_W(ID_W)) u_lsel (
        .clk(clk), .rst(rst), .sel_stb(sel_stb), .sel_id(sel_id),
        .sel_on(sel_on), .cs_mode(cs_mode), .set_m(ls_set), .clr_m(ls_clr)
    );

    always_comb begin
        frc_set = '0;
        frc_clr = '0;
        if (cmd.wr && cmd.sel == REG_FORCE) begin
            frc_set = bus_wdata[DATA_W-1:NUM_PINS];
            frc_clr = bus_wdata[NUM_PINS-1:0];
        end
    end

    csel_state #(.NUM_PINS(NUM_PINS)) u_state (
        .clk(clk), .rst(rst),
        .set_m(frc_set | ls_set), .clr_m(frc_clr | ls_clr),
        .stored(stored)
    );

    always_comb begin
        case (cmd.sel)
            REG_CFG:    rd_next = {cs_mode, invert};
            REG_STATUS: rd_next = {{NUM_PINS{1'b0}}, stored};
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= cmd.rd;
            if (cmd.rd) rdata_q <= rd_next;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign pin_out    = stored ^ invert;
    assign pin_gpo    = ~cs_mode;

    // R11: valid follows the strobe by exactly one cycle
    a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

endmodule

// File: tb/test_csel_out_ctrl.sv
`timescale 1ns/1ps
module test_csel_out_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        sel_stb = 1'b0, sel_on = 1'b0;
    logic [3:0]  sel_id = '0;
    logic [7:0]  pin_out, pin_gpo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model built from the requirements
    logic [7:0]  m_store = 8'hFF;
    logic [15:0] m_cfg   = 16'h0000;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    csel_out_ctrl i_csel_out_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .sel_stb(sel_stb), .sel_id(sel_id),
        .sel_on(sel_on), .pin_out(pin_out), .pin_gpo(pin_gpo)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design presents it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected rvalid", 16'h1, 16'h0);
            end else begin
                string t;
                logic [15:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    // one bus/select cycle, model updated from R3, R4, R8, R9, R10
    task automatic step(input logic wr, input logic rd, input logic [1:0] addr,
                        input logic [15:0] wd, input logic stb,
                        input logic [3:0] id, input logic on, input string rtag);
        logic [7:0] s, c;
        s = '0; c = '0;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        sel_stb = stb; sel_id = id; sel_on = on;
        if (rd) begin
            case (addr)
                2'd0:    exp_q.push_back(m_cfg);
                2'd2:    exp_q.push_back({8'h00, m_store});
                default: exp_q.push_back(16'h0000);
            endcase
            tag_q.push_back(rtag);
        end
        if (wr && addr == 2'd1) begin
            s = wd[15:8];
            c = wd[7:0];
        end
        if (stb && id >= 4'd1 && id <= 4'd8 && m_cfg[8 + id - 1]) begin
            if (on) c[id - 1] = 1'b1;
            else    s[id - 1] = 1'b1;
        end
        m_store = (m_store | s) & ~c;
        if (wr && addr == 2'd0) m_cfg = wd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; sel_stb = 0;
    endtask

    task automatic check_pins(input string req);
        chk({req, " pin_out"}, {8'h00, pin_out}, {8'h00, m_store ^ m_cfg[7:0]});
        chk({req, " pin_gpo"}, {8'h00, pin_gpo}, {8'h00, ~m_cfg[15:8]});
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        step(1, 0, a, d, 0, 4'd0, 0, "");
    endtask

    task automatic rd_reg(input logic [1:0] a, input string t);
        step(0, 1, a, 16'h0, 0, 4'd0, 0, t);
    endtask

    task automatic lsel(input logic [3:0] id, input logic on);
        step(0, 0, 2'd0, 16'h0, 1, id, on, "");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", {8'h00, pin_out}, 16'h00FF);
        chk("R1 pin_gpo", {8'h00, pin_gpo}, 16'h00FF);
        chk("R11 rvalid idle", {15'h0, bus_rvalid}, 16'h0);
        rd_reg(2'd2, "R1 R6 status after reset");
        rd_reg(2'd0, "R1 R2 cfg after reset");
        rd_reg(2'd1, "R6 force reads zero");

        // R3 clear all, then set all with 0xFF00
        wr_reg(2'd1, 16'h00FF); check_pins("R3 clear all");
        wr_reg(2'd1, 16'hFF00); check_pins("R3 set all");
        rd_reg(2'd2, "R3 R6 status all set");
        wr_reg(2'd1, 16'h0005); check_pins("R3 partial clear");
        rd_reg(2'd2, "R3 zero bits unchanged");
        // R4 both halves for pins 0 and 1
        wr_reg(2'd1, 16'h0303); check_pins("R4 clear wins");
        rd_reg(2'd2, "R4 status");
        // walking set/clear sweep
        for (int n = 0; n < 8; n++) begin
            wr_reg(2'd1, 16'h0001 << n); check_pins("R3 walk clear");
            wr_reg(2'd1, 16'h0100 << n); check_pins("R3 walk set");
        end
        wr_reg(2'd1, 16'h00AA); check_pins("R3 pattern");

        // R2 R5 R7 config: select mode on pins 4..7, invert pins 0..3
        wr_reg(2'd0, 16'hF00F); check_pins("R5 R7 cfg applied");
        rd_reg(2'd0, "R2 cfg readback");
        wr_reg(2'd1, 16'h0F00); check_pins("R5 inverted set");

        // R8 logical select
        lsel(4'd5, 1); check_pins("R8 select 5 asserts pin 4");
        rd_reg(2'd2, "R8 status pin4 clear");
        lsel(4'd2, 1); check_pins("R8 gpo pin ignores select");
        rd_reg(2'd2, "R8 status after gpo select");
        lsel(4'd8, 1); check_pins("R8 select 8 edge");
        lsel(4'd8, 0); check_pins("R8 release 8");
        // R9 out of range numbers
        lsel(4'd0, 1);  check_pins("R9 id 0");
        lsel(4'd9, 1);  check_pins("R9 id 9");
        lsel(4'd15, 0); check_pins("R9 id 15");
        rd_reg(2'd2, "R9 status unchanged");

        // R10 same-cycle force and select
        step(1, 0, 2'd1, 16'h1000, 1, 4'd5, 1, ""); check_pins("R10 select clear beats force set");
        step(1, 0, 2'd1, 16'h0040, 1, 4'd7, 0, ""); check_pins("R10 force clear beats select set");
        step(1, 0, 2'd1, 16'h0100, 1, 4'd6, 1, ""); check_pins("R10 disjoint both apply");
        rd_reg(2'd2, "R10 status");
        wr_reg(2'd1, 16'hFF00); check_pins("R3 final set all");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule